// File: doc/BRIEF.md
# Flagged Byte-Stream Hit Record Deframer

This block takes bytes from a receive FIFO and rebuilds fixed-size hit records from them. Each byte carries a two-bit framing flag in its two lowest bits and six payload bits above them. The flag says whether the byte opens a packet, continues it, closes it, or should be thrown away. The block strips the flags and shifts the payload into a record register, most significant bits first. Each record holds four 24-bit signed fixed-point fields: 8 integer bits including the sign, and 16 fractional bits. The fields are the x, y and z wire coordinates and the drift distance.

Sixteen accepted bytes make one 96-bit record. Each completed record leaves the block with a one-cycle valid strobe. The block also pulses a marker when a packet opens and when it closes. It reports stray bytes that arrive outside a packet, and tails that arrive in the middle of a record.

A two-state controller governs the block.
- In the state `ST_IDLE`, no packet is open. A head byte moves the controller to `ST_OPEN` (transition *open*). A body or tail byte stays in `ST_IDLE` and is reported as an orphan (transition *orphan*).
- In `ST_OPEN`, a body byte keeps the state (transition *extend*). A head byte keeps the state but starts the packing again (transition *restart*). A tail byte returns to `ST_IDLE` (transition *close*).

Top module: `hit_deframer`

## Requirements
- R1: After reset, every pulse output is low, `orphan_cnt` is 0, and no packet is open.
- R2: When `in_valid` is high, `in_byte[1:0]` selects the byte kind: 01 is head, 00 is body, 10 is tail and 11 is invalid. `in_byte[7:2]` is the 6-bit payload.
- R3: Payload is shifted in most significant first, and 16 accepted bytes form one record. The first byte's payload lands in `rec_data[95:90]`. The fields are x in [95:72], y in [71:48], z in [47:24] and drift distance in [23:0]. `rec_valid` is high for exactly one cycle, the cycle after the edge that samples the 16th byte, and `rec_data` holds the record in that cycle.
- R4: A byte with flag 11, and any cycle with `in_valid` low, changes no state and produces no output pulse.
- R5: A body or tail byte that arrives while no packet is open is discarded. It raises `err_orphan` for one cycle, one cycle after the byte, and increments `orphan_cnt`.
- R6: A head byte always opens a fresh packet, also in the middle of a packet. It pulses `sop` one cycle later and silently discards any partial record. Its own payload becomes the first 6 bits of the new record.
- R7: A tail byte that completes a record produces `rec_valid` and `eop` in the same cycle, and the packet closes.
- R8: A tail byte that leaves the record incomplete produces `eop` and `err_partial` together, with no `rec_valid`, and the partial record is discarded.
- R9: `orphan_cnt` saturates at its maximum value (255 with the default width).
- R10: A packet may carry several records back to back. Each record is emitted as soon as its 16th byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_byte` holds a byte this cycle |
| in_byte | input | 8 | Flag in [1:0], payload in [7:2] |
| rec_valid | output | 1 | One-cycle strobe for a completed record |
| rec_data | output | 96 | Record: x, y, z, drift distance |
| sop | output | 1 | Packet opened |
| eop | output | 1 | Packet closed |
| err_orphan | output | 1 | Body or tail byte arrived with no packet open |
| err_partial | output | 1 | Tail byte arrived in the middle of a record |
| orphan_cnt | output | 8 | Saturating count of orphan bytes |

## Verification
The packing path is tried with the following patterns:
- Single-record and three-record packets with distinct field values. These separate correct bit order and field placement from swapped or shifted layouts.
- The same packets with invalid bytes and idle cycles spread inside them. These show whether such gaps leak into the packing count.
- Misaligned tails and heads placed in the middle of a record. These separate discarding a record from emitting it early.
- Long runs of stray body and tail bytes. These show the orphan path and that its count stops at the maximum.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_HEAD = 2'd1,
        K_BODY = 2'd2,
        K_TAIL = 2'd3
    } byte_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } dfr_state_t;

    localparam logic [1:0] FLG_BODY    = 2'b00;
    localparam logic [1:0] FLG_HEAD    = 2'b01;
    localparam logic [1:0] FLG_TAIL    = 2'b10;
    localparam logic [1:0] FLG_INVALID = 2'b11;

endpackage

// File: rtl/hd_flag_decode.sv
module hd_flag_decode
    import hd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FLAG_W = 2,
    localparam int PAY_W = BYTE_W - FLAG_W
) (
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output byte_kind_t        kind,
    output logic [PAY_W-1:0]  pay
);

    logic [1:0] flg;

    assign flg = in_byte[1:0];
    assign pay = in_byte[BYTE_W-1:FLAG_W];

    always_comb begin
        kind = K_NONE;
        if (in_valid) begin
            unique case (flg)
                FLG_HEAD:    kind = K_HEAD;
                FLG_BODY:    kind = K_BODY;
                FLG_TAIL:    kind = K_TAIL;
                FLG_INVALID: kind = K_NONE;
                default:     kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/hd_packer.sv
module hd_packer #(
    parameter int PAY_W = 6,
    parameter int REC_W = 96,
    localparam int BPR   = REC_W / PAY_W,
    localparam int CNT_W = (BPR > 1) ? $clog2(BPR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             restart,
    input  logic             flush,
    input  logic [PAY_W-1:0] pay,
    output logic             wrap,
    output logic             rec_valid,
    output logic [REC_W-1:0] rec_data
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] base_cnt;
    logic [REC_W-1:0] shreg;
    logic [REC_W-1:0] base_sh;
    logic [REC_W-1:0] next_sh;

    always_comb begin
        base_cnt = restart ? '0 : cnt;
        base_sh  = restart ? '0 : shreg;
        next_sh  = {base_sh[REC_W-PAY_W-1:0], pay};
        wrap     = push && (base_cnt == CNT_W'(BPR - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            rec_valid <= 1'b0;
            rec_data  <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (push) begin
                shreg <= next_sh;
                if (wrap || flush) cnt <= '0;
                else               cnt <= base_cnt + 1'b1;
                if (wrap) begin
                    rec_valid <= 1'b1;
                    rec_data  <= next_sh;
                end
            end
        end
    end

    // R3: a completed record always leaves the byte counter at zero
    a_r3_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> cnt == '0);

    // R4: with nothing pushed, the counter holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(cnt));

endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl
    import hd_pkg::*;
#(
    parameter int OCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  byte_kind_t        kind,
    input  logic              wrap,
    output logic              push,
    output logic              restart,
    output logic              flush,
    output logic              sop,
    output logic              eop,
    output logic              err_orphan,
    output logic              err_partial,
    output logic [OCNT_W-1:0] orphan_cnt
);

    dfr_state_t state, nxt;
    logic sop_d, eop_d, orph_d, part_d;

    always_comb begin
        nxt     = state;
        push    = 1'b0;
        restart = 1'b0;
        flush   = 1'b0;
        sop_d   = 1'b0;
        eop_d   = 1'b0;
        orph_d  = 1'b0;
        part_d  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (kind == K_HEAD) begin
                    push    = 1'b1;
                    restart = 1'b1;
                    sop_d   = 1'b1;
                    nxt     = ST_OPEN;
                end else if (kind == K_BODY || kind == K_TAIL) begin
                    orph_d  = 1'b1;
                end
            end
            ST_OPEN: begin
                unique case (kind)
                    K_HEAD: begin
                        push    = 1'b1;
                        restart = 1'b1;
                        sop_d   = 1'b1;
                    end
                    K_BODY: push = 1'b1;
                    K_TAIL: begin
                        push   = 1'b1;
                        flush  = 1'b1;
                        eop_d  = 1'b1;
                        part_d = !wrap;
                        nxt    = ST_IDLE;
                    end
                    default: ;
                endcase
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sop         <= 1'b0;
            eop         <= 1'b0;
            err_orphan  <= 1'b0;
            err_partial <= 1'b0;
            orphan_cnt  <= '0;
        end else begin
            sop         <= sop_d;
            eop         <= eop_d;
            err_orphan  <= orph_d;
            err_partial <= part_d;
            if (orph_d && orphan_cnt != '1)
                orphan_cnt <= orphan_cnt + 1'b1;
        end
    end

    // R5: an orphan report is only raised while no packet is open
    a_r5_orphan_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |-> state == ST_IDLE);

    // R8: a partial-record error always comes with the packet close
    a_r8_partial_eop: assert property (@(posedge clk) disable iff (!rst_n)
        err_partial |-> eop);

    // R9: once at its maximum, the orphan count stays there
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        orphan_cnt == '1 |=> orphan_cnt == '1);

    // R6: a packet-open pulse leaves the controller in the open state
    a_r6_sop_open: assert property (@(posedge clk) disable iff (!rst_n)
        sop |-> state == ST_OPEN);

endmodule

// File: rtl/hit_deframer.sv
module hit_deframer
    import hd_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FLAG_W  = 2,
    parameter int FIELD_W = 24,
    parameter int FIELDS  = 4,
    parameter int OCNT_W  = 8,
    localparam int PAY_W  = BYTE_W - FLAG_W,
    localparam int REC_W  = FIELD_W * FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              rec_valid,
    output logic [REC_W-1:0]  rec_data,
    output logic              sop,
    output logic              eop,
    output logic              err_orphan,
    output logic              err_partial,
    output logic [OCNT_W-1:0] orphan_cnt
);

    byte_kind_t       kind;
    logic [PAY_W-1:0] pay;
    logic             push, restart, flush, wrap;

    hd_flag_decode #(.BYTE_W(BYTE_W), .FLAG_W(FLAG_W)) u_dec (
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .kind     (kind),
        .pay      (pay)
    );

    hd_ctrl #(.OCNT_W(OCNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind        (kind),
        .wrap        (wrap),
        .push        (push),
        .restart     (restart),
        .flush       (flush),
        .sop         (sop),
        .eop         (eop),
        .err_orphan  (err_orphan),
        .err_partial (err_partial),
        .orphan_cnt  (orphan_cnt)
    );

    hd_packer #(.PAY_W(PAY_W), .REC_W(REC_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .restart   (restart),
        .flush     (flush),
        .pay       (pay),
        .wrap      (wrap),
        .rec_valid (rec_valid),
        .rec_data  (rec_data)
    );

    // R8: a record strobe and a partial-record error never coincide
    a_r8_no_record_on_partial: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_valid, err_partial}));

    // R4: an invalid flag or an idle input cycle yields no pulse next cycle
    a_r4_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || in_byte[1:0] == 2'b11) |=>
            !(rec_valid || sop || eop || err_orphan || err_partial));

endmodule

// File: tb/hit_deframer_tb_top.sv
module hit_deframer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        rec_valid, sop, eop, err_orphan, err_partial;
    logic [95:0] rec_data;
    logic [7:0]  orphan_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit        m_open = 0;
    bit [5:0]  m_q[$];
    int        m_ocnt = 0;

    always #4 clk = ~clk;

    hit_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .rec_valid(rec_valid), .rec_data(rec_data), .sop(sop), .eop(eop),
        .err_orphan(err_orphan), .err_partial(err_partial),
        .orphan_cnt(orphan_cnt)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model the byte, compare at next negedge
    task automatic step(input bit v, input logic [7:0] b, input string tag);
        bit e_rv = 0, e_sop = 0, e_eop = 0, e_orph = 0, e_part = 0;
        logic [95:0] e_rec = '0;
        bit [5:0] p;
        bit [1:0] f;
        bit ok;
        in_valid = v;
        in_byte  = b;
        p = b[7:2];
        f = b[1:0];
        if (v && f != 2'b11) begin
            if (f == 2'b01) begin
                m_q.delete();
                m_q.push_back(p);
                m_open = 1;
                e_sop = 1;
            end else if (!m_open) begin
                e_orph = 1;
                if (m_ocnt < 255) m_ocnt++;
            end else begin
                m_q.push_back(p);
                if (m_q.size() == 16) begin
                    e_rv = 1;
                    for (int k = 0; k < 16; k++)
                        e_rec[95-6*k -: 6] = m_q[k];
                    m_q.delete();
                end
                if (f == 2'b10) begin
                    e_eop = 1;
                    e_part = !e_rv;
                    m_q.delete();
                    m_open = 0;
                end
            end
        end
        @(negedge clk);
        ok = (rec_valid == e_rv) && (sop == e_sop) && (eop == e_eop) &&
             (err_orphan == e_orph) && (err_partial == e_part) &&
             (orphan_cnt == 8'(m_ocnt)) && (!e_rv || rec_data == e_rec);
        check(ok, tag,
              $sformatf("rv/sop/eop/orph/part/cnt=%b%b%b%b%b/%0d",
                        rec_valid, sop, eop, err_orphan, err_partial, orphan_cnt),
              {rec_valid, sop, eop, err_orphan, err_partial, orphan_cnt, rec_data[63:0]},
              {e_rv, e_sop, e_eop, e_orph, e_part, 8'(m_ocnt), e_rec[63:0]});
    endtask

    function automatic logic [7:0] mk(input logic [95:0] r, input int k,
                                      input logic [1:0] f);
        return {r[95-6*k -: 6], f};
    endfunction

    // send one record's 16 bytes; first may be head, last may be tail
    task automatic send_rec(input logic [95:0] r, input bit first_head,
                            input bit last_tail, input bit gaps, input string tag);
        for (int k = 0; k < 16; k++) begin
            logic [1:0] f;
            f = 2'b00;
            if (k == 0 && first_head) f = 2'b01;
            if (k == 15 && last_tail) f = 2'b10;
            if (gaps && (k % 5 == 2)) begin
                step(1'b1, 8'hAB | 8'h03, "R4");
                step(1'b0, 8'h55, "R4");
            end
            step(1'b1, mk(r, k, f), tag);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [95:0] r1, r2, r3;
        r1 = {24'h01A972, 24'h000CED, 24'h020000, 24'h00066B};
        r2 = {24'hFF8001, 24'h7FFFFF, 24'h123456, 24'hABCDEF};
        r3 = {24'h800000, 24'h000001, 24'h5A5A5A, 24'hC3C3C3};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!rec_valid && !sop && !eop && !err_orphan && !err_partial &&
              orphan_cnt == 0, "R1", "reset outputs",
              {rec_valid, sop, eop, err_orphan, err_partial, orphan_cnt}, '0);
        rst_n = 1'b1;
        step(1'b0, 8'h00, "R1");
        // R2 R3 R7 single-record packet
        send_rec(r1, 1, 1, 0, "R7");
        // R10 three records in one packet, with gaps (R4)
        send_rec(r1, 1, 0, 1, "R10");
        send_rec(r2, 0, 0, 1, "R10");
        send_rec(r3, 0, 1, 0, "R3");
        // R5 orphan body and tail
        step(1'b1, 8'hFC, "R5");
        step(1'b1, 8'h12, "R5");
        // R8 misaligned tail
        for (int k = 0; k < 7; k++) step(1'b1, mk(r2, k, k == 0 ? 2'b01 : 2'b00), "R8");
        step(1'b1, 8'h36, "R8");
        // R6 head in middle of a record, then a full record
        for (int k = 0; k < 9; k++) step(1'b1, mk(r3, k, k == 0 ? 2'b01 : 2'b00), "R6");
        send_rec(r2, 1, 1, 0, "R6");
        // R8 tail after one record plus extra bytes
        send_rec(r1, 1, 0, 0, "R8");
        step(1'b1, 8'h04, "R8");
        step(1'b1, 8'h06, "R8");
        // R4 invalid-only bytes
        for (int k = 0; k < 6; k++) step(1'b1, 8'(k * 40) | 8'h03, "R4");
        // R9 saturation of the orphan count
        for (int k = 0; k < 270; k++) step(1'b1, (k % 2) ? 8'h02 : 8'h00, "R9");
        check(orphan_cnt == 8'd255, "R9", "saturated count", 96'(orphan_cnt), 96'd255);
        // after saturation a packet still works
        send_rec(r3, 1, 1, 1, "R3");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule